// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block is a small register-mapped interrupt unit for a single class of error source. A hardware event pulse sets a sticky status bit. Software clears that bit by writing 1 to it. A mask decides whether a pending status bit raises the one level-sensitive interrupt line.

Software can read the mask but cannot write it directly. To change the mask, software writes to one of two write-only command registers. One command register unmasks the bits written as 1. The other masks the bits written as 1. Both command registers read back as zero. The source starts out masked after reset.

A separate control register holds one enable bit for bus error responses. The block only stores this bit and drives it out; the responses themselves are produced elsewhere.

The register bus is 32 bits wide and little-endian. It accepts only aligned word accesses. A write happens in the cycle where the write strobe is high. Read data is combinational from the address.

Top module: `isr_ctrl`

## Requirements
- R1: After reset the status reads 0, the mask reads all ones, the control register reads 0, and both `irq` and `err_resp_en` are 0.
- R2: The status register is at offset 0x4, with the event bit in bit 0. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R3: The mask register is at offset 0x8 and reads back the current mask in its low bits. Any write to offset 0x8 leaves the mask unchanged.
- R4: A write to the unmask register at offset 0xC clears each mask bit written as 1 and leaves the others unchanged. Reading 0xC returns 0.
- R5: A write to the mask-set register at offset 0x10 sets each mask bit written as 1 and leaves the others unchanged. Reading 0x10 returns 0.
- R6: An event input bit high at a clock edge sets the matching status bit. The event wins over a write-1-to-clear of that bit at the same edge.
- R7: `irq` is registered. After each edge it equals 1 exactly when some status bit is 1 while its mask bit is 0. It therefore changes one cycle after the write or event that causes the change.
- R8: The control register is at offset 0x0. Bit 0 is read/write and drives `err_resp_en`. The other bits read as 0.
- R9: Any offset other than 0x0, 0x4, 0x8, 0xC or 0x10, including any address with bits [1:0] not 00, reads 0. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | ADDR_W | Byte offset of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| event_in | input | SRC_W | Hardware event pulses, one per status bit |
| irq | output | 1 | Level interrupt, registered |
| err_resp_en | output | 1 | Bus error response enable, from control bit 0 |

## Verification
The hardest case is a hardware event landing in the same cycle as a write-1-to-clear of the status bit, because the two sources disagree on the bit's next value. The bench drives an event pulse in the cycle that carries the clearing write, and then checks that the status stays set and that `irq` follows.

The stimulus also covers direct writes to the read-only mask and misaligned addresses that alias mapped offsets. After a directed sequence, random traffic over every mapped and some unmapped offsets runs against a behavioural model on every clock.

// File: rtl/isr_ctrl_pkg.sv
package isr_ctrl_pkg;

  localparam int unsigned OFS_ERRCTL  = 32'h00;
  localparam int unsigned OFS_STATUS  = 32'h04;
  localparam int unsigned OFS_MASK    = 32'h08;
  localparam int unsigned OFS_UNMASK  = 32'h0C;
  localparam int unsigned OFS_DOMASK  = 32'h10;
  localparam int unsigned BUS_W       = 32;

  typedef struct packed {
    logic errctl;
    logic status;
    logic mask;
    logic unmask;
    logic domask;
  } reg_hit_t;

  // status after clear-by-one and set-by-event; set wins
  function automatic logic [31:0] f_next_status(input logic [31:0] cur,
                                                input logic [31:0] clr,
                                                input logic [31:0] set);
    return (cur & ~clr) | set;
  endfunction

  // mask after unmask and mask-set commands
  function automatic logic [31:0] f_next_mask(input logic [31:0] cur,
                                              input logic [31:0] unm,
                                              input logic [31:0] dom);
    return (cur & ~unm) | dom;
  endfunction

  function automatic logic f_pending(input logic [31:0] st,
                                     input logic [31:0] mk);
    return |(st & ~mk);
  endfunction

endpackage

// File: rtl/isr_addr_decode.sv
module isr_addr_decode
  import isr_ctrl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_hit_t          hit
);

  always_comb begin
    hit = '0;
    if (addr[1:0] == 2'b00) begin
      case (addr)
        ADDR_W'(OFS_ERRCTL): hit.errctl = 1'b1;
        ADDR_W'(OFS_STATUS): hit.status = 1'b1;
        ADDR_W'(OFS_MASK):   hit.mask   = 1'b1;
        ADDR_W'(OFS_UNMASK): hit.unmask = 1'b1;
        ADDR_W'(OFS_DOMASK): hit.domask = 1'b1;
        default:             hit        = '0;
      endcase
    end
  end

  // R9: at most one register selected, none for misaligned offsets
  always_comb begin
    assert ($onehot0(hit)) else $error("p_onehot_hit_r9");
    if (addr[1:0] != 2'b00)
      assert (hit == '0) else $error("p_misaligned_nohit_r9");
  end

endmodule

// File: rtl/isr_state.sv
module isr_state
  import isr_ctrl_pkg::*;
#(
  parameter int SRC_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_clr_we,
  input  logic             unmask_we,
  input  logic             domask_we,
  input  logic [SRC_W-1:0] wdata,
  input  logic [SRC_W-1:0] event_in,
  output logic [SRC_W-1:0] status,
  output logic [SRC_W-1:0] mask,
  output logic             irq
);

  logic [SRC_W-1:0] clr_bits, unm_bits, dom_bits;
  logic [SRC_W-1:0] status_nx, mask_nx;
  logic             irq_nx;

  assign clr_bits  = st_clr_we ? wdata : '0;
  assign unm_bits  = unmask_we ? wdata : '0;
  assign dom_bits  = domask_we ? wdata : '0;
  assign status_nx = SRC_W'(f_next_status(32'(status), 32'(clr_bits), 32'(event_in)));
  assign mask_nx   = SRC_W'(f_next_mask(32'(mask), 32'(unm_bits), 32'(dom_bits)));
  assign irq_nx    = f_pending(32'(status_nx), 32'(mask_nx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '1;
      irq    <= 1'b0;
    end else begin
      status <= status_nx;
      mask   <= mask_nx;
      irq    <= irq_nx;
    end
  end

  // R7: registered interrupt agrees with stored state after every edge
  p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(status & ~mask)));

  // R3: mask moves only under a command write
  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!unmask_we && !domask_we) |=> $stable(mask));

  for (genvar g = 0; g < SRC_W; g++) begin : g_bit
    p_event_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      event_in[g] |=> status[g]);
    p_w1c_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_clr_we && wdata[g] && !event_in[g]) |=> !status[g]);
    p_unmask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (unmask_we && wdata[g] && !domask_we) |=> !mask[g]);
    p_domask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (domask_we && wdata[g]) |=> mask[g]);
  end

endmodule

// File: rtl/isr_read_mux.sv
module isr_read_mux
  import isr_ctrl_pkg::*;
#(
  parameter int SRC_W = 1
) (
  input  reg_hit_t         hit,
  input  logic [SRC_W-1:0] status,
  input  logic [SRC_W-1:0] mask,
  input  logic             errctl_q,
  output logic [BUS_W-1:0] rd_data
);

  always_comb begin
    rd_data = '0;
    if (hit.errctl) rd_data[0]         = errctl_q;
    if (hit.status) rd_data[SRC_W-1:0] = status;
    if (hit.mask)   rd_data[SRC_W-1:0] = mask;
  end

  // R4 R5: command registers never return data
  always_comb begin
    if (hit.unmask || hit.domask)
      assert (rd_data == '0) else $error("p_cmd_reads_zero_r4");
  end

endmodule

// File: rtl/isr_ctrl.sv
module isr_ctrl
  import isr_ctrl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SRC_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [SRC_W-1:0]  event_in,
  output logic              irq,
  output logic              err_resp_en
);

  reg_hit_t         hit;
  logic [SRC_W-1:0] status, mask;
  logic             errctl_q;
  logic             st_clr_we, unmask_we, domask_we, errctl_we;

  isr_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .hit  (hit)
  );

  assign st_clr_we = wr_en & hit.status;
  assign unmask_we = wr_en & hit.unmask;
  assign domask_we = wr_en & hit.domask;
  assign errctl_we = wr_en & hit.errctl;

  isr_state #(.SRC_W(SRC_W)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_clr_we (st_clr_we),
    .unmask_we (unmask_we),
    .domask_we (domask_we),
    .wdata     (wr_data[SRC_W-1:0]),
    .event_in  (event_in),
    .status    (status),
    .mask      (mask),
    .irq       (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         errctl_q <= 1'b0;
    else if (errctl_we) errctl_q <= wr_data[0];
  end

  assign err_resp_en = errctl_q;

  isr_read_mux #(.SRC_W(SRC_W)) u_rd (
    .hit      (hit),
    .status   (status),
    .mask     (mask),
    .errctl_q (errctl_q),
    .rd_data  (rd_data)
  );

  // R8: control bit follows a write to offset 0x0
  p_errctl_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit.errctl) |=> (err_resp_en == $past(wr_data[0])));

  // R9: writes outside the map touch no state
  p_unmapped_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit == '0 && event_in == '0) |=> ($stable(status) && $stable(mask) && $stable(err_resp_en)));

endmodule

// File: tb/isr_ctrl_test.sv
`timescale 1ns/1ps
module isr_ctrl_test;

  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wr_data = '0;
  logic [31:0]       rd_data;
  logic [0:0]        event_in = '0;
  logic              irq;
  logic              err_resp_en;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // behavioural reference state
  int m_status, m_mask, m_ec, m_irq;

  always #2 clk = ~clk;

  isr_ctrl #(.ADDR_W(ADDR_W), .SRC_W(1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .event_in(event_in), .irq(irq), .err_resp_en(err_resp_en)
  );

  function automatic int model_read(input int a);
    case (a)
      0:  return m_ec;
      4:  return m_status;
      8:  return m_mask;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0:  return "R8";
      4:  return "R2";
      8:  return "R3";
      12: return "R4";
      16: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit we, input int a, input int d, input bit ev);
    @(negedge clk);
    wr_en = we; addr = ADDR_W'(a); wr_data = d; event_in = ev;
    #1 check(tag_of(a), int'(rd_data), model_read(a));
    @(posedge clk);
    if (we) begin
      case (a)
        0:  m_ec = d & 1;
        4:  m_status = m_status & ~(d & 1);
        12: m_mask = m_mask & ~(d & 1);
        16: m_mask = m_mask | (d & 1);
        default: ;
      endcase
    end
    if (ev) m_status = 1;
    m_irq = (m_status & ~m_mask) & 1;
    #1;
    check("R7", int'(irq), m_irq);
    check("R8", int'(err_resp_en), m_ec);
  endtask

  task automatic rd(input int a);
    cyc(0, a, 0, 0);
  endtask

  initial begin
    m_status = 0; m_mask = 1; m_ec = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(irq), 0);
    check("R1", int'(err_resp_en), 0);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset values through the bus
    rd(0); rd(4); rd(8); rd(12); rd(16);
    // R6 event while masked: status set, R7 irq stays low
    cyc(0, 4, 0, 1); rd(4);
    // R4 unmask -> irq rises one cycle later
    cyc(1, 12, 1, 0); rd(8); rd(12);
    // R2 writing 0 keeps status
    cyc(1, 4, 0, 0); rd(4);
    // R2 write 1 clears
    cyc(1, 4, 1, 0); rd(4);
    // R6 event and clear in the same cycle: event wins
    cyc(0, 4, 0, 1);
    cyc(1, 4, 1, 1); rd(4);
    // R3 direct mask write ignored
    cyc(1, 8, 1, 0); rd(8);
    // R5 mask-set -> irq drops
    cyc(1, 16, 32'hFFFF_FFFF, 0); rd(8); rd(16);
    // R3 direct write of 0 to mask ignored
    cyc(1, 8, 0, 0); rd(8);
    // R8 control register
    cyc(1, 0, 32'hFFFF_FFFF, 0); rd(0);
    // R9 misaligned aliases of mapped offsets and unmapped offsets
    cyc(1, 5, 1, 0); cyc(1, 13, 1, 0); cyc(1, 2, 0, 0);
    cyc(1, 20, 32'hFFFF_FFFF, 0); cyc(1, 32'h100, 32'hFFFF_FFFF, 0);
    rd(8); rd(4); rd(0); rd(20); rd(6);
    cyc(1, 0, 0, 0); rd(0);
    // mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      int sel;
      int a;
      sel = int'($urandom_range(0, 7));
      a = (sel < 5) ? sel * 4 : ((sel == 5) ? 24 : int'($urandom_range(0, 40)));
      cyc(bit'($urandom_range(0, 1)), a, int'($urandom), bit'($urandom_range(0, 3) == 0));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule